// File: doc/BRIEF.md
# Transport System Time Counter with Packet Timestamp Capture

This block keeps the receiver's system time in the two-field format used by MPEG transport clock references. A 9-bit extension field counts modulo 300, and a 33-bit base field advances each time the extension wraps. The counter moves one step for each cycle of an external 27 MHz VCXO clock. That clock reaches the block as a single-cycle enable strobe, `tick`, which is synchronous to the block clock.

A pulse on `pkt_arrive` takes a snapshot of the running count. The snapshot goes out on a valid/ready stream as one 48-bit word: base in bits 47..15, six reserved bits (all ones) in bits 14..9, and the extension in bits 8..0. Software compares these timestamps with received clock references and steers the VCXO; that loop lies outside this block. A load port lets software preset both fields in one write.

Back-pressure rules for the timestamp stream: `ts_valid` stays high and `ts_data` stays constant until a cycle with `ts_ready` high. A capture that arrives while a word is pending and `ts_ready` is low is discarded. A capture that arrives in the same cycle as a handshake replaces the word, and `ts_valid` stays high.

Top module: `pcr_time_counter`

## Requirements
- R1: While `tick` is high and no load is pending, the extension steps by one per cycle from 0 to 299, and goes from 299 back to 0. It never holds a value above 299.
- R2: The base field increments by exactly one in the cycle the extension wraps from 299 to 0, and at no other time except a load.
- R3: At base 2^33-1 and extension 299, a tick gives base 0 and extension 0.
- R4: With `tick`, `load_en` and reset all low, both count fields hold their value.
- R5: A `pkt_arrive` pulse that is accepted puts `{base, 6'b111111, ext}` on `ts_data` in the next cycle: base in bits 47..15, reserved bits 14..9 set to ones, extension in bits 8..0.
- R6: A capture in the same cycle as a tick or a load records the count as it was before that update.
- R7: `ts_valid` rises the cycle after an accepted capture. It then holds, with `ts_data` stable, until a cycle with `ts_ready` high. After that cycle it drops, unless a new capture is accepted in the same cycle.
- R8: A capture while `ts_valid` is high and `ts_ready` is low is discarded. A capture in a handshake cycle replaces the word.
- R9: `load_en` writes base and extension together in one cycle and takes priority over `tick`.
- R10: A load with an extension value above 299 stores 299.
- R11: Synchronous reset (`rst` high at a clock edge) clears both count fields and `ts_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe per 27 MHz system time clock period |
| load_en | input | 1 | Load base and extension from the load inputs |
| load_base | input | 33 | Base value to load |
| load_ext | input | 9 | Extension value to load (clamped to 299) |
| pkt_arrive | input | 1 | Packet arrival pulse; requests a snapshot |
| ts_valid | output | 1 | Timestamp word is available |
| ts_ready | input | 1 | Consumer accepts the timestamp word |
| ts_data | output | 48 | Packed timestamp word |
| cnt_base | output | 33 | Live base field |
| cnt_ext | output | 9 | Live extension field |

## Verification
Assertions check the following on every cycle: the extension stays in range, wraps and clamps as required, the base moves only on a carry or a load, reset takes effect, a pending timestamp is held under back-pressure, and an accepted capture carries the pre-update count. The bench scenarios cover the rest. These are long tick runs that cross several wraps, rollover of the full 33-bit base, discarded captures, and captures that coincide with a tick, a load or a handshake. Each of these is observed only through the ports.

// File: rtl/pcrt_pkg.sv
package pcrt_pkg;
  localparam int DEF_BASE_W  = 33;
  localparam int DEF_EXT_W   = 9;
  localparam int DEF_RSV_W   = 6;
  localparam int DEF_EXT_MAX = 299;

  // counter action, decided once in the top and shared by both fields
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/pcrt_ext_counter.sv
module pcrt_ext_counter
  import pcrt_pkg::*;
#(
  parameter int EXT_W   = DEF_EXT_W,
  parameter int EXT_MAX = DEF_EXT_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_act_e         act,
  input  logic [EXT_W-1:0] load_ext,
  output logic [EXT_W-1:0] ext_q,
  output logic             carry
);
  localparam logic [EXT_W-1:0] MAX_V = EXT_W'(EXT_MAX);

  logic             at_max;
  logic [EXT_W-1:0] load_sat;

  assign at_max   = (ext_q == MAX_V);
  assign load_sat = (load_ext > MAX_V) ? MAX_V : load_ext;
  assign carry    = (act == ACT_STEP) && at_max;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: ext_q <= load_sat;
        ACT_STEP: ext_q <= at_max ? '0 : ext_q + EXT_W'(1);
        default:  ext_q <= ext_q;
      endcase
    end
  end

  p_ext_range_r1: assert property (@(posedge clk) disable iff (rst)
    ext_q <= MAX_V);
  p_ext_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STEP && ext_q == MAX_V) |=> ext_q == '0);
  p_ext_step_r1: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STEP && ext_q < MAX_V) |=> ext_q == $past(ext_q) + EXT_W'(1));
  p_ext_clamp_r10: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_LOAD && load_ext > MAX_V) |=> ext_q == MAX_V);
  p_ext_reset_r11: assert property (@(posedge clk)
    rst |=> ext_q == '0);
endmodule

// File: rtl/pcrt_base_counter.sv
module pcrt_base_counter
  import pcrt_pkg::*;
#(
  parameter int BASE_W = DEF_BASE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  cnt_act_e          act,
  input  logic              carry_in,
  input  logic [BASE_W-1:0] load_base,
  output logic [BASE_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (act == ACT_LOAD) begin
      base_q <= load_base;
    end else if (carry_in) begin
      base_q <= base_q + BASE_W'(1);
    end
  end

  p_base_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (carry_in && act != ACT_LOAD) |=> base_q == $past(base_q) + BASE_W'(1));
  p_base_still_r2: assert property (@(posedge clk) disable iff (rst)
    (!carry_in && act != ACT_LOAD) |=> $stable(base_q));
  p_base_load_r9: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_LOAD) |=> base_q == $past(load_base));
  p_base_reset_r11: assert property (@(posedge clk)
    rst |=> base_q == '0);
endmodule

// File: rtl/pcrt_snapshot.sv
module pcrt_snapshot
  import pcrt_pkg::*;
#(
  parameter int BASE_W = DEF_BASE_W,
  parameter int EXT_W  = DEF_EXT_W,
  parameter int RSV_W  = DEF_RSV_W,
  localparam int TS_W  = BASE_W + RSV_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [BASE_W-1:0] snap_base,
  input  logic [EXT_W-1:0]  snap_ext,
  output logic              valid,
  input  logic              ready,
  output logic [TS_W-1:0]   data
);
  localparam int EXT_LO = 0;
  localparam int RSV_LO = EXT_W;
  localparam int BAS_LO = EXT_W + RSV_W;

  logic accept;
  assign accept = capture && (!valid || ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (accept) begin
      valid <= 1'b1;
      data  <= {snap_base, {RSV_W{1'b1}}, snap_ext};
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> valid && $stable(data));
  p_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && ready && !capture) |=> !valid);
  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (capture && (!valid || ready)) |=>
      valid && data[BAS_LO +: BASE_W] == $past(snap_base)
            && data[EXT_LO +: EXT_W] == $past(snap_ext));
  p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    valid |-> data[RSV_LO +: RSV_W] == {RSV_W{1'b1}});
  p_valid_reset_r11: assert property (@(posedge clk)
    rst |=> !valid);
endmodule

// File: rtl/pcr_time_counter.sv
module pcr_time_counter
  import pcrt_pkg::*;
#(
  parameter int BASE_W  = DEF_BASE_W,
  parameter int EXT_W   = DEF_EXT_W,
  parameter int RSV_W   = DEF_RSV_W,
  parameter int EXT_MAX = DEF_EXT_MAX,
  localparam int TS_W   = BASE_W + RSV_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load_en,
  input  logic [BASE_W-1:0] load_base,
  input  logic [EXT_W-1:0]  load_ext,
  input  logic              pkt_arrive,
  output logic              ts_valid,
  input  logic              ts_ready,
  output logic [TS_W-1:0]   ts_data,
  output logic [BASE_W-1:0] cnt_base,
  output logic [EXT_W-1:0]  cnt_ext
);
  cnt_act_e act;
  logic     carry;

  // load outranks tick
  always_comb begin
    if (load_en)   act = ACT_LOAD;
    else if (tick) act = ACT_STEP;
    else           act = ACT_HOLD;
  end

  pcrt_ext_counter #(.EXT_W(EXT_W), .EXT_MAX(EXT_MAX)) u_ext (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .load_ext (load_ext),
    .ext_q    (cnt_ext),
    .carry    (carry)
  );

  pcrt_base_counter #(.BASE_W(BASE_W)) u_base (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .carry_in  (carry),
    .load_base (load_base),
    .base_q    (cnt_base)
  );

  // snapshot sees the registered count, i.e. the value before this cycle's update
  pcrt_snapshot #(.BASE_W(BASE_W), .EXT_W(EXT_W), .RSV_W(RSV_W)) u_snap (
    .clk       (clk),
    .rst       (rst),
    .capture   (pkt_arrive),
    .snap_base (cnt_base),
    .snap_ext  (cnt_ext),
    .valid     (ts_valid),
    .ready     (ts_ready),
    .data      (ts_data)
  );

  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_en) |=> $stable(cnt_base) && $stable(cnt_ext));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (load_en && load_ext <= EXT_W'(EXT_MAX)) |=>
      cnt_ext == $past(load_ext) && cnt_base == $past(load_base));
endmodule

// File: tb/pcr_time_counter_bench.sv
module pcr_time_counter_bench;
  typedef struct packed {
    logic [32:0] lb;
    logic [8:0]  le;
    logic [15:0] n;
    logic [32:0] eb;
    logic [8:0]  ee;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{33'd0,          9'd0,   16'd5,   33'd0,      9'd5},    // R1 steps
    '{33'd0,          9'd298, 16'd1,   33'd0,      9'd299},  // R1 top
    '{33'd0,          9'd299, 16'd1,   33'd1,      9'd0},    // R2 carry
    '{33'd7,          9'd299, 16'd301, 33'd9,      9'd0},    // R2 two carries
    '{33'h1FFFFFFFF,  9'd299, 16'd1,   33'd0,      9'd0},    // R3 rollover
    '{33'd100,        9'd400, 16'd0,   33'd100,    9'd299},  // R10 clamp
    '{33'd5,          9'd511, 16'd2,   33'd6,      9'd1},    // R10 clamp then count
    '{33'd123456,     9'd150, 16'd600, 33'd123458, 9'd150}   // R1 R2 long run
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        load_en = 1'b0;
  logic [32:0] load_base = '0;
  logic [8:0]  load_ext = '0;
  logic        pkt_arrive = 1'b0;
  logic        ts_valid;
  logic        ts_ready = 1'b0;
  logic [47:0] ts_data;
  logic [32:0] cnt_base;
  logic [8:0]  cnt_ext;
  int          total = 0;
  int          bad = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  pcr_time_counter u_pcr_time_counter (
    .clk(clk), .rst(rst), .tick(tick), .load_en(load_en),
    .load_base(load_base), .load_ext(load_ext), .pkt_arrive(pkt_arrive),
    .ts_valid(ts_valid), .ts_ready(ts_ready), .ts_data(ts_data),
    .cnt_base(cnt_base), .cnt_ext(cnt_ext)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input logic [32:0] b, input logic [8:0] e);
    chk({req, " base"}, 64'(cnt_base), 64'(b));
    chk({req, " ext"},  64'(cnt_ext),  64'(e));
  endtask

  task automatic chk_ts(input string req, input logic [32:0] b, input logic [8:0] e);
    chk({req, " valid"}, 64'(ts_valid), 64'd1);
    chk({req, " ts"}, 64'(ts_data), 64'({b, 6'b111111, e}));
  endtask

  task automatic load_val(input logic [32:0] b, input logic [8:0] e);
    load_en = 1'b1; load_base = b; load_ext = e;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic capture();
    pkt_arrive = 1'b1;
    @(negedge clk);
    pkt_arrive = 1'b0;
  endtask

  task automatic ack();
    ts_ready = 1'b1;
    @(negedge clk);
    ts_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_cnt("R11 reset", 33'd0, 9'd0);
    chk("R11 reset valid", 64'(ts_valid), 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      load_val(VECS[i].lb, VECS[i].le);
      run_ticks(int'(VECS[i].n));
      chk_cnt($sformatf("R1/R2/R3/R10 vec%0d", i), VECS[i].eb, VECS[i].ee);
      capture();
      chk_ts($sformatf("R5 vec%0d", i), VECS[i].eb, VECS[i].ee);
      chk("R5 reserved", 64'(ts_data[14:9]), 64'h3F);
      ack();
      chk("R7 drop after ack", 64'(ts_valid), 64'd0);
    end

    // R6: capture with tick in same cycle -> pre-increment value
    load_val(33'd3, 9'd299);
    tick = 1'b1; pkt_arrive = 1'b1;
    @(negedge clk);
    tick = 1'b0; pkt_arrive = 1'b0;
    chk_ts("R6 capture+tick", 33'd3, 9'd299);
    chk_cnt("R6 count moved", 33'd4, 9'd0);
    ack();

    // R6/R9: capture with load in same cycle
    load_en = 1'b1; load_base = 33'd50; load_ext = 9'd10; pkt_arrive = 1'b1;
    @(negedge clk);
    load_en = 1'b0; pkt_arrive = 1'b0;
    chk_ts("R6 capture+load", 33'd4, 9'd0);
    chk_cnt("R9 loaded", 33'd50, 9'd10);
    ack();

    // R9: load beats tick
    tick = 1'b1;
    load_val(33'd20, 9'd5);
    tick = 1'b0;
    chk_cnt("R9 load over tick", 33'd20, 9'd5);

    // R4: no tick -> hold
    repeat (10) @(negedge clk);
    chk_cnt("R4 hold", 33'd20, 9'd5);

    // R7: hold under back-pressure
    capture();
    repeat (5) @(negedge clk);
    chk_ts("R7 held", 33'd20, 9'd5);
    ack();
    chk("R7 cleared", 64'(ts_valid), 64'd0);

    // R8: discard while pending, replace on handshake
    capture();
    load_val(33'd30, 9'd0);
    capture();
    chk_ts("R8 discarded", 33'd20, 9'd5);
    pkt_arrive = 1'b1; ts_ready = 1'b1;
    @(negedge clk);
    pkt_arrive = 1'b0; ts_ready = 1'b0;
    chk_ts("R8 replaced", 33'd30, 9'd0);
    ack();
    chk("R8 cleared", 64'(ts_valid), 64'd0);

    // R11: reset mid-operation
    capture();
    run_ticks(7);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_cnt("R11 mid reset", 33'd0, 9'd0);
    chk("R11 mid reset valid", 64'(ts_valid), 64'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule